// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Controller

This block scans a passive dot-matrix LCD panel of up to 16 common lines by 32 segment lines (512 dots). A processor fills a 128-nibble display file through a write port that is one nibble wide. On each pulse of a scan strobe, which is derived from a slow timebase, the block moves to the next common line. For every common and segment pin it emits a small code that names the drive voltage level. An external analog stage turns these codes into the panel voltages.

The number of scanned commons can be set from 1 to 16. The bias scheme can be 1/4 or 1/5. After each complete frame the drive phase flips, so the panel sees no DC voltage. A mode field selects normal display, all dots on, all dots off or power-down. Power-down grounds every pin and freezes the scan. The segment data for the current common is held in a snapshot register. Processor writes therefore never change a row while it is being shown.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset the state is as follows: mode all-off, 16 commons scanned, bias 1/4, scan at common 0 and drive phase 0. A few cycles later, common 0 shows code 4, every other common shows code 1 and every segment shows code 2.
- R2: The level codes depend on the pin role and the drive phase. Let T be 4 for bias 1/4 (cfg_bias5=0) and 5 for bias 1/5 (cfg_bias5=1). In phase 0 a selected common shows T, an idle common shows 1, a lit segment shows 0 and a dark segment shows 2. In phase 1 a selected common shows 0, an idle common shows T-1, a lit segment shows T and a dark segment shows T-2. No code ever exceeds 5.
- R3: cfg_duty holds N-1, where N is the number of scanned commons. Each scan_tick moves the selected common one step up, from 0 to N-1 and then back to 0. Commons with an index above cfg_duty always show the idle code. The outputs reflect a tick after its third rising edge, so ticks must be at least 4 cycles apart.
- R4: The drive phase flips only when the scan wraps from the last scanned common back to common 0.
- R5: Nibble address k (wr_addr) holds the dots of common k[6:3]. Bit b of that nibble drives segment 4*k[2:0]+b.
- R6: cfg_mode has four values: 00 normal, 01 all-on (every segment lit), 10 all-off (every segment dark) and 11 power-down. In the all-on and all-off modes the commons keep scanning. A configuration write reaches the outputs by the second rising edge after the one that samples cfg_we.
- R7: In power-down every output code is 0 and scan_tick is ignored. On leaving power-down, the scan resumes from the same common, phase and row snapshot.
- R8: A write to display memory does not change the row that is being shown. The new data appears the next time its common is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle scan strobe from the slow timebase |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 7 | Display nibble index |
| wr_data | input | 4 | Nibble to write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Display mode |
| cfg_duty | input | 4 | Scanned commons minus one |
| cfg_bias5 | input | 1 | 1 selects 1/5 bias, 0 selects 1/4 |
| com_lvl | output | 48 | Three-bit level code per common, common i at bits 3i+2:3i |
| seg_lvl | output | 96 | Three-bit level code per segment, segment j at bits 3j+2:3j |

## Verification
Several properties are checked on every cycle:
- Every level code stays in range.
- A power-down mode that has lasted two cycles yields all-zero outputs.
- The scan position and phase never move without a tick, and never move in power-down.
- The phase changes only together with a wrap to common 0.
- The row snapshot changes only on its load strobe.

The exact codes for each bias and phase, the mapping of nibbles to dots, the shorter duty settings, the resume from power-down and the delayed arrival of written data can only be shown by the bench's scenarios, which compare whole output vectors against a reference model.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int LVL_W = 3;

  typedef enum logic [1:0] {
    DM_NORMAL     = 2'b00,
    DM_ALL_ON     = 2'b01,
    DM_ALL_OFF    = 2'b10,
    DM_POWER_DOWN = 2'b11
  } disp_mode_e;

  typedef enum logic [1:0] {
    ROLE_COM_SEL,
    ROLE_COM_IDLE,
    ROLE_SEG_ON,
    ROLE_SEG_OFF
  } pin_role_e;

  // Level index for a pin role; phase 1 mirrors the levels around mid-rail.
  function automatic logic [LVL_W-1:0] level_code(pin_role_e role, logic phase, logic bias5);
    logic [LVL_W-1:0] top;
    logic [LVL_W-1:0] code;
    top = bias5 ? LVL_W'(5) : LVL_W'(4);
    case (role)
      ROLE_COM_SEL:  code = phase ? LVL_W'(0) : top;
      ROLE_COM_IDLE: code = phase ? top - LVL_W'(1) : LVL_W'(1);
      ROLE_SEG_ON:   code = phase ? top : LVL_W'(0);
      default:       code = phase ? top - LVL_W'(2) : LVL_W'(2);
    endcase
    return code;
  endfunction

endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter  int N_ROWS  = 16,
  parameter  int N_BANKS = 8,
  parameter  int NIB_W   = 4,
  localparam int ROW_W   = $clog2(N_ROWS),
  localparam int BANK_W  = $clog2(N_BANKS)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [BANK_W-1:0]        wr_bank,
  input  logic [ROW_W-1:0]         wr_row,
  input  logic [NIB_W-1:0]         wr_data,
  input  logic [ROW_W-1:0]         rd_row,
  output logic [N_BANKS*NIB_W-1:0] rd_data
);

  // One narrow memory per nibble column so that a whole row reads in one cycle.
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [NIB_W-1:0] mem [N_ROWS];
    logic [NIB_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == BANK_W'(b))) begin
        mem[wr_row] <= wr_data;
      end
      rd_q <= mem[rd_row];
    end

    assign rd_data[b*NIB_W +: NIB_W] = rd_q;
  end

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter  int N_COM = 16,
  localparam int COM_W = $clog2(N_COM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic [COM_W-1:0] duty_m1,
  output logic [COM_W-1:0] com_idx,
  output logic             phase,
  output logic             row_load
);

  logic [COM_W-1:0] com_q;
  logic             phase_q;
  logic             req_q;
  logic             load_q;
  logic             step;

  assign step = tick && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      com_q   <= '0;
      phase_q <= 1'b0;
      req_q   <= 1'b1;   // fetch row 0 once after reset
      load_q  <= 1'b0;
    end else begin
      req_q  <= step;
      load_q <= req_q;
      if (step) begin
        if (com_q >= duty_m1) begin
          com_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          com_q <= com_q + COM_W'(1);
        end
      end
    end
  end

  assign com_idx  = com_q;
  assign phase    = phase_q;
  assign row_load = load_q;

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter  int N_COM = 16,
  parameter  int N_SEG = 32,
  localparam int COM_W = $clog2(N_COM)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  disp_mode_e             mode,
  input  logic                   bias5,
  input  logic [COM_W-1:0]       duty_m1,
  input  logic [COM_W-1:0]       sel_com,
  input  logic                   phase,
  input  logic [N_SEG-1:0]       row_bits,
  output logic [N_COM*LVL_W-1:0] com_lvl,
  output logic [N_SEG*LVL_W-1:0] seg_lvl
);

  wire [N_COM*LVL_W-1:0] com_nxt;
  wire [N_SEG*LVL_W-1:0] seg_nxt;
  logic                  pd;

  assign pd = (mode == DM_POWER_DOWN);

  for (genvar i = 0; i < N_COM; i++) begin : g_com
    logic active;
    assign active = (sel_com == COM_W'(i)) && (COM_W'(i) <= duty_m1);
    assign com_nxt[i*LVL_W +: LVL_W] = pd ? '0 :
        level_code(active ? ROLE_COM_SEL : ROLE_COM_IDLE, phase, bias5);
  end

  for (genvar j = 0; j < N_SEG; j++) begin : g_seg
    logic lit;
    assign lit = (mode == DM_ALL_ON) || ((mode == DM_NORMAL) && row_bits[j]);
    assign seg_nxt[j*LVL_W +: LVL_W] = pd ? '0 :
        level_code(lit ? ROLE_SEG_ON : ROLE_SEG_OFF, phase, bias5);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_nxt;
      seg_lvl <= seg_nxt;
    end
  end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter  int N_COM   = 16,
  parameter  int N_SEG   = 32,
  parameter  int NIB_W   = 4,
  localparam int N_BANKS = N_SEG / NIB_W,
  localparam int COM_W   = $clog2(N_COM),
  localparam int BANK_W  = $clog2(N_BANKS),
  localparam int ADDR_W  = COM_W + BANK_W,
  localparam int OUT_CW  = N_COM * LVL_W,
  localparam int OUT_SW  = N_SEG * LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [COM_W-1:0]  cfg_duty,
  input  logic              cfg_bias5,
  output logic [OUT_CW-1:0] com_lvl,
  output logic [OUT_SW-1:0] seg_lvl
);

  disp_mode_e       mode_q;
  logic [COM_W-1:0] duty_q;
  logic             bias5_q;

  logic [COM_W-1:0] com_idx;
  logic             scan_phase;
  logic             row_load;
  logic [N_SEG-1:0] ram_row;

  logic [N_SEG-1:0] row_buf;
  logic [COM_W-1:0] shown_com;
  logic             shown_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= DM_ALL_OFF;
      duty_q  <= COM_W'(N_COM - 1);
      bias5_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= disp_mode_e'(cfg_mode);
      duty_q  <= cfg_duty;
      bias5_q <= cfg_bias5;
    end
  end

  lcd_scan_seq #(.N_COM(N_COM)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (scan_tick),
    .halt     (mode_q == DM_POWER_DOWN),
    .duty_m1  (duty_q),
    .com_idx  (com_idx),
    .phase    (scan_phase),
    .row_load (row_load)
  );

  lcd_disp_ram #(.N_ROWS(N_COM), .N_BANKS(N_BANKS), .NIB_W(NIB_W)) ram_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_addr[BANK_W-1:0]),
    .wr_row  (wr_addr[ADDR_W-1:BANK_W]),
    .wr_data (wr_data),
    .rd_row  (com_idx),
    .rd_data (ram_row)
  );

  // Whole-row snapshot: updated in a single cycle, so a row is never torn.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_buf     <= '0;
      shown_com   <= '0;
      shown_phase <= 1'b0;
    end else if (row_load) begin
      row_buf     <= ram_row;
      shown_com   <= com_idx;
      shown_phase <= scan_phase;
    end
  end

  lcd_level_enc #(.N_COM(N_COM), .N_SEG(N_SEG)) enc_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .bias5    (bias5_q),
    .duty_m1  (duty_q),
    .sel_com  (shown_com),
    .phase    (shown_phase),
    .row_bits (row_buf),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk #(
  parameter  int N_COM = 16,
  parameter  int N_SEG = 32,
  localparam int COM_W = $clog2(N_COM),
  localparam int LW    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic [1:0]          mode_q,
  input logic [COM_W-1:0]    com_idx,
  input logic                phase,
  input logic                row_load,
  input logic [N_SEG-1:0]    row_buf,
  input logic [N_COM*LW-1:0] com_lvl,
  input logic [N_SEG*LW-1:0] seg_lvl
);

  for (genvar i = 0; i < N_COM; i++) begin : g_crange
    assert_com_range_R2: assert property (@(posedge clk) disable iff (rst)
      com_lvl[i*LW +: LW] <= LW'(5));
  end

  for (genvar j = 0; j < N_SEG; j++) begin : g_srange
    assert_seg_range_R2: assert property (@(posedge clk) disable iff (rst)
      seg_lvl[j*LW +: LW] <= LW'(5));
  end

  assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11 && $past(mode_q) == 2'b11) |-> (com_lvl == '0 && seg_lvl == '0));

  assert_pd_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11) |=> ($stable(com_idx) && $stable(phase)));

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(com_idx));

  assert_phase_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (com_idx == '0));

  assert_row_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !row_load |=> $stable(row_buf));

endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (scan_tick),
  .mode_q   (mode_q),
  .com_idx  (com_idx),
  .phase    (scan_phase),
  .row_load (row_load),
  .row_buf  (row_buf),
  .com_lvl  (com_lvl),
  .seg_lvl  (seg_lvl)
);

// File: tb/lcd_scan_ctrl_tb_top.sv
module lcd_scan_ctrl_tb_top;

  localparam int NC = 16;
  localparam int NS = 32;
  localparam int NV = 26;
  localparam logic [1:0] OP_TICK = 2'd0, OP_WR = 2'd1, OP_CFG = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] req;
    logic [6:0] a;
    logic [3:0] d;
  } vec_t;

  // CFG: a[4]=bias5, a[3:0]=duty-1, d[1:0]=mode. WR: a=nibble index, d=data.
  localparam vec_t VECS [NV] = '{
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3 step to common 1
    '{OP_CFG,  4'd6, 7'h0F, 4'h0},  // R6 normal, row 1 shown
    '{OP_TICK, 4'd5, 7'h00, 4'h0},  // R5 row 2 mapping
    '{OP_CFG,  4'd2, 7'h1F, 4'h0},  // R2 bias 1/5
    '{OP_CFG,  4'd6, 7'h1F, 4'h1},  // R6 all-on
    '{OP_CFG,  4'd6, 7'h1F, 4'h2},  // R6 all-off
    '{OP_CFG,  4'd3, 7'h12, 4'h0},  // R3 duty 1/3
    '{OP_TICK, 4'd4, 7'h00, 4'h0},  // R4 wrap, phase 1
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3
    '{OP_TICK, 4'd4, 7'h00, 4'h0},  // R4 wrap, phase 0
    '{OP_CFG,  4'd7, 7'h12, 4'h3},  // R7 power-down
    '{OP_TICK, 4'd7, 7'h00, 4'h0},  // R7 tick ignored
    '{OP_WR,   4'd8, 7'h09, 4'hA},  // R8 write while down
    '{OP_CFG,  4'd7, 7'h02, 4'h0},  // R7 resume, bias 1/4
    '{OP_WR,   4'd8, 7'h00, 4'hC},  // R8 write to shown row
    '{OP_TICK, 4'd8, 7'h00, 4'h0},  // R8 row 1 new data
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3
    '{OP_TICK, 4'd8, 7'h00, 4'h0},  // R8 row 0 new data
    '{OP_CFG,  4'd3, 7'h00, 4'h0},  // R3 duty 1/1
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3
    '{OP_TICK, 4'd4, 7'h00, 4'h0},  // R4
    '{OP_CFG,  4'd3, 7'h1F, 4'h0},  // R3 duty 1/16
    '{OP_TICK, 4'd3, 7'h00, 4'h0},  // R3
    '{OP_WR,   4'd5, 7'h7F, 4'h5},  // R5 last nibble
    '{OP_CFG,  4'd6, 7'h1F, 4'h1}   // R6 all-on
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [3:0] cfg_duty = '0;
  logic cfg_bias5 = 1'b0;
  logic [NC*3-1:0] com_lvl;
  logic [NS*3-1:0] seg_lvl;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model
  logic [3:0]    m_mem [128];
  logic [1:0]    m_mode;
  logic [3:0]    m_duty;
  logic          m_b5;
  int            m_com;
  logic          m_ph;
  int            s_com;
  logic          s_ph;
  logic [NS-1:0] s_row;

  always #2 clk = ~clk;

  lcd_scan_ctrl dut_i (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_duty(cfg_duty),
    .cfg_bias5(cfg_bias5), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] exp_code(int role, logic ph, logic b5);
    int t = b5 ? 5 : 4;
    int v;
    case (role)
      0: v = ph ? 0 : t;       // common selected
      1: v = ph ? t - 1 : 1;   // common idle
      2: v = ph ? t : 0;       // segment lit
      default: v = ph ? t - 2 : 2;
    endcase
    return 3'(v);
  endfunction

  function automatic logic [NS-1:0] model_row(int r);
    logic [NS-1:0] v;
    for (int b = 0; b < 8; b++) v[b*4 +: 4] = m_mem[r*8 + b];
    return v;
  endfunction

  task automatic check(string tag);
    logic [NC*3-1:0] ec;
    logic [NS*3-1:0] es;
    for (int i = 0; i < NC; i++)
      ec[i*3 +: 3] = (m_mode == 2'b11) ? 3'd0 :
                     exp_code((i == s_com && i <= int'(m_duty)) ? 0 : 1, s_ph, m_b5);
    for (int j = 0; j < NS; j++) begin
      logic lit;
      lit = (m_mode == 2'b01) || (m_mode == 2'b00 && s_row[j]);
      es[j*3 +: 3] = (m_mode == 2'b11) ? 3'd0 : exp_code(lit ? 2 : 3, s_ph, m_b5);
    end
    checks++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      fails++;
      $display("FAIL %s com act %h exp %h seg act %h exp %h", tag, com_lvl, ec, seg_lvl, es);
    end
  endtask

  task automatic model_reset();
    m_mode = 2'b10; m_duty = 4'd15; m_b5 = 1'b0;
    m_com = 0; m_ph = 1'b0; s_com = 0; s_ph = 1'b0;
    s_row = model_row(0);
  endtask

  task automatic apply(logic [1:0] op, logic [6:0] a, logic [3:0] d);
    @(negedge clk);
    case (op)
      OP_TICK: scan_tick = 1'b1;
      OP_WR: begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      default: begin
        cfg_we = 1'b1; cfg_mode = d[1:0]; cfg_duty = a[3:0]; cfg_bias5 = a[4];
      end
    endcase
    @(negedge clk);
    scan_tick = 1'b0; wr_en = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    case (op)
      OP_TICK: if (m_mode != 2'b11) begin
        if (m_com >= int'(m_duty)) begin m_com = 0; m_ph = ~m_ph; end
        else m_com = m_com + 1;
        s_com = m_com; s_ph = m_ph; s_row = model_row(m_com);
      end
      OP_WR: m_mem[a] = d;
      default: begin m_mode = d[1:0]; m_duty = a[3:0]; m_b5 = a[4]; end
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 100000);
    fails++;
    $display("FAIL watchdog expired act %0d cycles exp fewer", cyc);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 128; k++) m_mem[k] = 4'((k * 5 + 3) & 15);
    s_row = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    s_row = '0;
    repeat (4) @(negedge clk);
    check("R1 reset state");

    // fill the display file (state stays all-off)
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'(k); wr_data = m_mem[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R1 all-off after fill");

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].op, VECS[v].a, VECS[v].d);
      check($sformatf("R%0d vec %0d", VECS[v].req, v));
    end

    // R3 R5: full 1/16 sweep in normal mode, bias 1/4
    apply(OP_CFG, 7'h0F, 4'h0);
    check("R3 sweep start");
    for (int s = 0; s < 17; s++) begin
      apply(OP_TICK, 7'h00, 4'h0);
      check($sformatf("R5 sweep step %0d", s));
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    check("R1 reset mid-run");
    apply(OP_CFG, 7'h0F, 4'h0);
    check("R1 row 0 after reset");

    finish_run();
  end

endmodule